// File: doc/BRIEF.md
# Latched Change-Event Interrupt Controller

This block watches four per-channel condition inputs: loss of signal, driver fault, alarm indication and loopback status. It turns any change of an enabled condition into a pending event. A change in either direction counts, rising or falling. Each pending event is held in a sticky flag until the host acknowledges it. While any flag is pending, the block pulls a shared open-drain interrupt line low. Several devices can wire their outputs together on that line.

The host reaches three 4-bit registers through a simple select/write/address port. Reads are combinational.

Register map:

| Address | Register | Access |
|---|---|---|
| 0 | Mask | read/write |
| 1 | Live conditions | read-only; reading clears every sticky flag |
| 2 | Sticky flags | read-only; no side effect |

Bit order is the same in all three registers:

| Bit | Source |
|---|---|
| 0 | Loss of signal |
| 1 | Driver fault |
| 2 | Alarm indication |
| 3 | Loopback |

The condition inputs are asynchronous. Each passes through a two-flop synchroniser. Edges are found by comparing the synchronised value with a registered copy of its previous value.

Top module: `latched_irq_ctrl`

## Requirements
- R1: After reset the mask and sticky flag registers read 0, and the interrupt line is released (`irq_oe`=0, `irq_hiz`=1).
- R2: A write with `bus_addr`=0 loads the mask register. A read at address 0 returns it. Bit 0 is loss of signal, bit 1 driver fault, bit 2 alarm indication, bit 3 loopback.
- R3: A read at address 1 returns the synchronised live conditions. A change on `cond_i` becomes visible there after two rising clock edges.
- R4: A 0-to-1 change of an unmasked condition sets its flag in the register at address 2, on the third rising edge after the input change.
- R5: A 1-to-0 change of an unmasked condition also sets its flag.
- R6: Changes on a source whose mask bit is 0 leave its flag at 0 and do not pull the line.
- R7: `irq_oe` is 1 and `irq_hiz` is 0 while any flag is set. Both return to the released state once no flags remain.
- R8: A read of address 1 clears all sticky flags at the clock edge that ends the read.
- R9: Reading address 2 does not change any flag.
- R10: If a new change is detected in the same cycle as a clearing read, its flag stays set.
- R11: Writing a mask bit to 0 clears that source's pending flag.
- R12: Writes to addresses 1, 2 and 3 have no effect, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cond_i | input | 4 | Asynchronous condition inputs, bit order as in R2 |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, combinational from the address |
| irq_oe | output | 1 | Pull-down enable for the shared interrupt line (1 = drive low) |
| irq_hiz | output | 1 | 1 while the line is left floating for the external pull-up |

## Verification
Single-source rising and falling changes show that both edge directions latch. A source toggled while masked must leave its flag clear, which separates masking from level detection. Two sources changing in opposite directions in the same cycle show that flags are kept per bit. A change timed so that its detection cycle meets a clearing read of the live register separates the intended set-wins priority from a clear-wins one. A mask bit written to 0 while its flag is pending must drop both that flag and the line.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NSRC_DEF = 4;
  localparam int AW_DEF   = 2;

  // Bit position of each source in every register
  typedef enum int {
    SRC_LOS   = 0,
    SRC_DRVF  = 1,
    SRC_ALARM = 2,
    SRC_LOOP  = 3
  } src_idx_e;

  typedef enum logic [1:0] {
    ADDR_MASK = 2'd0,
    ADDR_LIVE = 2'd1,
    ADDR_FLAG = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d_i;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_i,
  output logic [W-1:0] prev_o,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] flag_q, flag_d;
  logic [W-1:0] chg;
  logic         flag_en;

  always_comb begin
    chg     = live_i ^ prev_q;
    // set has priority over the clearing read
    flag_d  = ((flag_q & ~{W{clr_i}}) | chg) & mask_i;
    flag_en = clr_i | (|chg) | (|(flag_q & ~mask_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= live_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign prev_o = prev_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_ctrl_pkg::*;
#(
  parameter int W  = 4,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  live_i,
  input  logic [W-1:0]  flag_i,
  output logic [W-1:0]  mask_o,
  output logic [W-1:0]  rdata_o,
  output logic          clr_o
);
  logic [W-1:0] mask_q, mask_d;
  logic         mask_en;

  always_comb begin
    mask_en = sel_i & we_i & (addr_i == AW'(ADDR_MASK));
    mask_d  = wdata_i;
    clr_o   = sel_i & ~we_i & (addr_i == AW'(ADDR_LIVE));
    case (addr_i)
      AW'(ADDR_MASK): rdata_o = mask_q;
      AW'(ADDR_LIVE): rdata_o = live_i;
      AW'(ADDR_FLAG): rdata_o = flag_i;
      default:        rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/latched_irq_ctrl.sv
module latched_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NSRC        = NSRC_DEF,
  parameter int AW          = AW_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] cond_i,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic            irq_oe,
  output logic            irq_hiz
);
  logic [1:0]      rst_pipe_q;
  logic            rst_s;
  logic [NSRC-1:0] live_q, prev_q, flag_q, mask_q;
  logic            clr_live;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s = rst_pipe_q[1];

  irq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s), .d_i(cond_i), .q_o(live_q)
  );

  irq_edge_latch #(.W(NSRC)) u_latch (
    .clk(clk), .rst_n(rst_s), .live_i(live_q), .mask_i(mask_q),
    .clr_i(clr_live), .prev_o(prev_q), .flag_o(flag_q)
  );

  irq_regif #(.W(NSRC), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_s), .sel_i(bus_sel), .we_i(bus_we),
    .addr_i(bus_addr), .wdata_i(bus_wdata), .live_i(live_q),
    .flag_i(flag_q), .mask_o(mask_q), .rdata_o(bus_rdata), .clr_o(clr_live)
  );

  assign irq_oe  = |flag_q;
  assign irq_hiz = ~irq_oe;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NSRC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] flags,
  input logic [NSRC-1:0] live,
  input logic [NSRC-1:0] prev,
  input logic            clr,
  input logic            irq_oe,
  input logic            irq_hiz,
  input logic            sel,
  input logic            we,
  input logic [1:0]      addr
);
  // R6
  masked_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(mask)) == '0));

  // R4
  new_flag_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(live ^ prev)) == '0));

  // R10
  enabled_change_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((live ^ prev) & mask) != '0 |=> (($past((live ^ prev) & mask) & ~flags) == '0));

  // R7
  line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> (!irq_oe && irq_hiz));

  // R7
  line_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags != '0) |-> (irq_oe && !irq_hiz));

  // R8
  live_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !we && addr == 2'd1 && (live ^ prev) == '0) |=> (flags == '0));

  // R9
  flag_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !we && addr == 2'd2 && $stable(mask)) |=> ((($past(flags) & mask) & ~flags) == '0));
endmodule

bind latched_irq_ctrl irq_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_s), .mask(mask_q), .flags(flag_q), .live(live_q),
  .prev(prev_q), .clr(clr_live), .irq_oe(irq_oe), .irq_hiz(irq_hiz),
  .sel(bus_sel), .we(bus_we), .addr(bus_addr)
);

// File: tb/sim_latched_irq_ctrl.sv
module sim_latched_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cond_i = '0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [3:0] bus_wdata = '0;
  logic [3:0] bus_rdata;
  logic       irq_oe, irq_hiz;

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  event       rd_ev;

  always #2 clk = ~clk;

  latched_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_oe(irq_oe), .irq_hiz(irq_hiz)
  );

  // monitor: pops expected read data and compares
  initial forever begin
    @(rd_ev);
    begin
      logic [3:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata actual %b expected %b", t, bus_rdata, e);
      end
    end
  end

  task automatic bus_read(input logic [1:0] a, input logic [3:0] e, input string t);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    #1 -> rd_ev;
    @(posedge clk);
    #1 bus_sel = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic set_cond(input logic [3:0] v);
    @(negedge clk);
    cond_i = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_line(input logic oe_e, input string t);
    @(negedge clk);
    n_chk++;
    if (irq_oe !== oe_e || irq_hiz !== ~oe_e) begin
      n_fail++;
      $display("FAIL %s: oe/hiz actual %b/%b expected %b/%b", t, irq_oe, irq_hiz, oe_e, ~oe_e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_line(1'b0, "R1 line released");
    bus_read(2'd0, 4'b0000, "R1 mask reset");
    bus_read(2'd2, 4'b0000, "R1 flags reset");

    set_cond(4'b0001);
    bus_read(2'd2, 4'b0000, "R6 masked change");
    chk_line(1'b0, "R6 line idle");
    bus_read(2'd1, 4'b0001, "R3 live value");

    bus_write(2'd0, 4'b1111);
    bus_read(2'd0, 4'b1111, "R2 mask readback");
    bus_write(2'd1, 4'b1010);
    bus_write(2'd2, 4'b1111);
    bus_read(2'd0, 4'b1111, "R12 mask untouched");
    bus_read(2'd2, 4'b0000, "R12 flags untouched");
    bus_read(2'd3, 4'b0000, "R12 empty address");

    set_cond(4'b0011);
    bus_read(2'd2, 4'b0010, "R4 rising edge flag");
    chk_line(1'b1, "R7 line driven");
    bus_read(2'd2, 4'b0010, "R9 flag read no side effect");

    bus_read(2'd1, 4'b0011, "R8 live read");
    bus_read(2'd2, 4'b0000, "R8 flags cleared");
    chk_line(1'b0, "R7 line released");

    set_cond(4'b0010);
    bus_read(2'd2, 4'b0001, "R5 falling edge flag");
    bus_read(2'd1, 4'b0010, "R8 live read 2");

    // change detected in the same cycle as the clearing read
    @(negedge clk);
    cond_i = 4'b0110;
    @(posedge clk);
    @(posedge clk);
    bus_read(2'd1, 4'b0110, "R10 live during race");
    bus_read(2'd2, 4'b0100, "R10 set wins over clear");
    chk_line(1'b1, "R10 line still driven");
    bus_read(2'd1, 4'b0110, "R8 clear after race");

    set_cond(4'b1110);
    bus_read(2'd2, 4'b1000, "R4 loopback flag");
    bus_write(2'd0, 4'b0111);
    repeat (2) @(negedge clk);
    bus_read(2'd2, 4'b0000, "R11 mask clear drops flag");
    chk_line(1'b0, "R11 line released");
    set_cond(4'b0110);
    bus_read(2'd2, 4'b0000, "R6 masked loopback toggle");

    set_cond(4'b0011);
    bus_read(2'd2, 4'b0101, "R5 two sources opposite edges");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule